// File: doc/BRIEF.md
# Message Buffer Transfer Sequencer

This block moves message buffers between a communication controller's message RAM and system data RAM with no processor involvement. A configuration table with one entry per buffer number tells the engine where the buffer lives in system memory, which directions it may move in, which sections to copy, whether a transmit request follows a copy into the controller, and whether a copy toward system memory depends on update flags. Work is queued by manual triggers for each direction and by frame-completion events from the controller. A pending buffer is then served word by word over two simple request/acknowledge memory ports.

Every buffer is laid out as a header of `HDR_WORDS` words (word indices 0..3), a data section of `DATA_WORDS` words and one status word. Each word crosses as a read on the source port followed by a write on the destination port. Before any access, the engine checks the buffer's whole system-memory span against a single protection window. A violation stops the engine until software clears it.

Top module: `xfer_seq`

## Requirements
- R1: A table entry is 23 bits with a separate parity bit, and the 24 bits together must have even parity. Entry bits [15:0] hold the word offset, bit 16 allows copies to system memory and bit 17 allows copies to the controller. Bit 18 selects the header, bit 19 selects the data, bit 20 is auto-send and bits [22:21] are the condition. When a served entry fails parity, its pending request is dropped with no memory access, the sticky parity flag is set and the parity interrupt pulses.
- R2: With W = HDR_WORDS+DATA_WORDS+1, word i of buffer b has controller address b*W+i and system address offset+i. Words move in ascending index over the selected sections. Header words are indices 0..3, data words follow them, and the status word (index HDR_WORDS+DATA_WORDS) is copied only toward system memory, always last.
- R3: Among pending buffers, the lowest buffer number is served first.
- R4: When one buffer is pending in both directions, prio_i=1 serves the copy to the controller first and prio_i=0 serves the copy to system memory first.
- R5: Manual triggers queue a copy for each direction. A request for a direction the entry does not allow, or for an entry with neither section selected, is dropped without any access.
- R6: An event on an armed buffer queues a copy to system memory. A one-shot arm clears on its first event, and a continuous arm stays set.
- R7: The condition code applies to copies toward system memory: 0 always, 1 needs stat_upd_i[b], 2 needs data_upd_i[b], 3 needs either. If it is not met, the request is dropped.
- R8: The window is half-open [lo, hi) and both bounds are zero after reset, so it is empty. The span offset..offset+W-1 must lie inside it. Otherwise the request is dropped with no access, the sticky flag is set, the interrupt pulses and no buffer is served until clr_err_i. Window writes take effect only while idle.
- R9: busy_o and cur_buf_o show the buffer being moved, and last_sys_o and last_cc_o show the last buffer completed in each direction.
- R10: Each completed buffer pulses done_irq_o for one cycle unless done_mask_i[b] is set.
- R11: A completed copy to the controller from an auto-send entry pulses tx_req_o with tx_buf_o = b, one cycle after the last write is acknowledged.
- R12: After reset the engine is idle, all flags, interrupts and last-buffer registers are zero, and the table entries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| cfg_we_i | input | 1 | table entry write |
| cfg_buf_i | input | BW | entry index |
| cfg_ent_i | input | ENT_W | entry contents |
| cfg_par_i | input | 1 | entry parity bit |
| win_we_i | input | 1 | window write |
| win_lo_i | input | AW | window start (inclusive) |
| win_hi_i | input | AW | window end (exclusive) |
| prio_i | input | 1 | same-buffer direction priority |
| clr_err_i | input | 1 | clear sticky error flags |
| trig_sys_i | input | 1 | manual trigger toward system memory |
| trig_cc_i | input | 1 | manual trigger toward controller |
| trig_buf_i | input | BW | triggered buffer |
| arm_i | input | 1 | arm event trigger |
| arm_cont_i | input | 1 | arm as continuous |
| arm_buf_i | input | BW | armed buffer |
| evt_i | input | 1 | frame completion event |
| evt_buf_i | input | BW | event buffer |
| stat_upd_i | input | NUM_BUF | status-updated flags |
| data_upd_i | input | NUM_BUF | data-updated flags |
| done_mask_i | input | NUM_BUF | completion interrupt masks |
| cc_req_o | output | 1 | controller port request |
| cc_we_o | output | 1 | controller port write |
| cc_addr_o | output | CAW | controller word address |
| cc_wdata_o | output | DW | controller write data |
| cc_rdata_i | input | DW | controller read data |
| cc_ack_i | input | 1 | controller acknowledge |
| sm_req_o | output | 1 | system port request |
| sm_we_o | output | 1 | system port write |
| sm_addr_o | output | AW | system word address |
| sm_wdata_o | output | DW | system write data |
| sm_rdata_i | input | DW | system read data |
| sm_ack_i | input | 1 | system acknowledge |
| busy_o | output | 1 | a buffer is being moved |
| cur_buf_o | output | BW | buffer being moved |
| last_sys_o | output | BW | last buffer done toward system |
| last_cc_o | output | BW | last buffer done toward controller |
| done_irq_o | output | 1 | completion interrupt pulse |
| par_flag_o | output | 1 | sticky parity error |
| par_irq_o | output | 1 | parity interrupt pulse |
| mpv_flag_o | output | 1 | sticky protection violation |
| mpv_irq_o | output | 1 | protection interrupt pulse |
| tx_req_o | output | 1 | transmit request pulse |
| tx_buf_o | output | BW | buffer for transmit request |

## Verification
Some properties are checked on every cycle. The assertions confirm that system-memory requests never leave the protection window, that nothing is served while a violation is pending, and that the violation and parity interrupts agree with their flags. They also confirm that a transmit request only follows an acknowledged controller write, that a waiting request holds its address, and that the two ports are never requested together. Other behaviour only the bench's scenarios can show, using its queue of expected writes: the lowest-number-first ordering, the direction priority on a shared buffer, the section and status-word selection, one-shot versus continuous arming, the update conditions and the interrupt masking.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int SYS_AW = 16;

    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} st_e;

    // Bit order (MSB first) is decoded by the sequencer: [22:21] cond,
    // [20] auto-send, [19:18] sections {data,header}, [17:16] directions
    // {to controller,to system}, [15:0] word offset in system memory.
    typedef struct packed {
        logic [1:0]        cond;
        logic              autos;
        logic [1:0]        sel;
        logic [1:0]        dirm;
        logic [SYS_AW-1:0] ofs;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);
endpackage

// File: rtl/xfer_pick.sv
module xfer_pick #(
    parameter int N = 128,
    localparam int BW = $clog2(N)
) (
    input  logic [N-1:0]  pend_sys_i,
    input  logic [N-1:0]  pend_cc_i,
    input  logic          prio_i,
    output logic          vld_o,
    output logic [BW-1:0] buf_o,
    output logic          to_cc_o
);
    // Scan from the top so the lowest pending index is the one left standing.
    always_comb begin
        vld_o   = 1'b0;
        buf_o   = '0;
        to_cc_o = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_sys_i[i] || pend_cc_i[i]) begin
                vld_o   = 1'b1;
                buf_o   = BW'(i);
                to_cc_o = pend_cc_i[i] && (prio_i || !pend_sys_i[i]);
            end
        end
    end
endmodule

// File: rtl/xfer_win.sv
module xfer_win #(
    parameter int AW   = 16,
    parameter int SPAN = 9
) (
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    input  logic [AW-1:0] base_i,
    output logic          ok_o
);
    logic [AW:0] end_w;

    assign end_w = {1'b0, base_i} + (AW + 1)'(SPAN);
    // Half-open window: lo >= hi can never contain a non-empty span.
    assign ok_o  = (base_i >= lo_i) && (end_w <= {1'b0, hi_i});
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int NUM_BUF    = 128,
    parameter int HDR_WORDS  = 4,
    parameter int DATA_WORDS = 4,
    parameter int DW         = 32,
    localparam int AW        = SYS_AW,
    localparam int BW        = $clog2(NUM_BUF),
    localparam int BUF_WORDS = HDR_WORDS + DATA_WORDS + 1,
    localparam int STAT_IDX  = HDR_WORDS + DATA_WORDS,
    localparam int IW        = $clog2(BUF_WORDS + 1),
    localparam int CAW       = $clog2(NUM_BUF * BUF_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we_i,
    input  logic [BW-1:0]      cfg_buf_i,
    input  logic [ENT_W-1:0]   cfg_ent_i,
    input  logic               cfg_par_i,
    input  logic               win_we_i,
    input  logic [AW-1:0]      win_lo_i,
    input  logic [AW-1:0]      win_hi_i,
    input  logic               prio_i,
    input  logic               clr_err_i,
    input  logic               trig_sys_i,
    input  logic               trig_cc_i,
    input  logic [BW-1:0]      trig_buf_i,
    input  logic               arm_i,
    input  logic               arm_cont_i,
    input  logic [BW-1:0]      arm_buf_i,
    input  logic               evt_i,
    input  logic [BW-1:0]      evt_buf_i,
    input  logic [NUM_BUF-1:0] stat_upd_i,
    input  logic [NUM_BUF-1:0] data_upd_i,
    input  logic [NUM_BUF-1:0] done_mask_i,
    output logic               cc_req_o,
    output logic               cc_we_o,
    output logic [CAW-1:0]     cc_addr_o,
    output logic [DW-1:0]      cc_wdata_o,
    input  logic [DW-1:0]      cc_rdata_i,
    input  logic               cc_ack_i,
    output logic               sm_req_o,
    output logic               sm_we_o,
    output logic [AW-1:0]      sm_addr_o,
    output logic [DW-1:0]      sm_wdata_o,
    input  logic [DW-1:0]      sm_rdata_i,
    input  logic               sm_ack_i,
    output logic               busy_o,
    output logic [BW-1:0]      cur_buf_o,
    output logic [BW-1:0]      last_sys_o,
    output logic [BW-1:0]      last_cc_o,
    output logic               done_irq_o,
    output logic               par_flag_o,
    output logic               par_irq_o,
    output logic               mpv_flag_o,
    output logic               mpv_irq_o,
    output logic               tx_req_o,
    output logic [BW-1:0]      tx_buf_o
);
    typedef struct packed {
        st_e                st;
        logic [BW-1:0]      bufn;
        logic               to_cc;
        logic [IW-1:0]      idx;
        logic               dat;
        logic               autos;
        logic [AW-1:0]      ofs;
        logic [DW-1:0]      word;
        logic [NUM_BUF-1:0] p_sys;
        logic [NUM_BUF-1:0] p_cc;
        logic [NUM_BUF-1:0] arm;
        logic [NUM_BUF-1:0] cont;
        logic [AW-1:0]      wlo;
        logic [AW-1:0]      whi;
        logic               mpv;
        logic               perr;
        logic [BW-1:0]      last_sys;
        logic [BW-1:0]      last_cc;
        logic               done_irq;
        logic               par_irq;
        logic               mpv_irq;
        logic               tx;
    } reg_t;

    reg_t r_d, r_q;
    logic [ENT_W:0] tbl_q [NUM_BUF];

    logic          pk_vld, pk_cc, win_ok, ent_bad, cond_ok, dir_ok;
    logic [BW-1:0] pk_buf;
    ent_t          ent;
    logic          src_ack, dst_ack;
    logic [DW-1:0] src_rdata;
    logic [IW-1:0] last_idx;
    logic [AW-1:0] win_lo_w, win_hi_w;

    xfer_pick #(.N(NUM_BUF)) u_pick (
        .pend_sys_i (r_q.p_sys),
        .pend_cc_i  (r_q.p_cc),
        .prio_i     (prio_i),
        .vld_o      (pk_vld),
        .buf_o      (pk_buf),
        .to_cc_o    (pk_cc)
    );

    assign ent     = ent_t'(tbl_q[pk_buf][ENT_W-1:0]);
    assign ent_bad = ^tbl_q[pk_buf];

    xfer_win #(.AW(AW), .SPAN(BUF_WORDS)) u_win (
        .lo_i   (r_q.wlo),
        .hi_i   (r_q.whi),
        .base_i (ent.ofs),
        .ok_o   (win_ok)
    );

    always_comb begin
        unique case (ent.cond)
            2'd0:    cond_ok = 1'b1;
            2'd1:    cond_ok = stat_upd_i[pk_buf];
            2'd2:    cond_ok = data_upd_i[pk_buf];
            default: cond_ok = stat_upd_i[pk_buf] || data_upd_i[pk_buf];
        endcase
    end

    assign dir_ok    = (ent.sel != 2'b00) && (pk_cc ? ent.dirm[1] : (ent.dirm[0] && cond_ok));
    assign src_ack   = r_q.to_cc ? sm_ack_i : cc_ack_i;
    assign dst_ack   = r_q.to_cc ? cc_ack_i : sm_ack_i;
    assign src_rdata = r_q.to_cc ? sm_rdata_i : cc_rdata_i;
    assign last_idx  = !r_q.to_cc ? IW'(STAT_IDX) :
                       (r_q.dat ? IW'(STAT_IDX - 1) : IW'(HDR_WORDS - 1));

    always_comb begin
        r_d          = r_q;
        r_d.done_irq = 1'b0;
        r_d.par_irq  = 1'b0;
        r_d.mpv_irq  = 1'b0;
        r_d.tx       = 1'b0;
        if (clr_err_i) begin
            r_d.mpv  = 1'b0;
            r_d.perr = 1'b0;
        end
        unique case (r_q.st)
            ST_IDLE: begin
                if (win_we_i) begin
                    r_d.wlo = win_lo_i;
                    r_d.whi = win_hi_i;
                end
                if (pk_vld && !r_q.mpv) begin
                    if (pk_cc) r_d.p_cc[pk_buf]  = 1'b0;
                    else       r_d.p_sys[pk_buf] = 1'b0;
                    if (ent_bad) begin
                        r_d.perr    = 1'b1;
                        r_d.par_irq = 1'b1;
                    end else if (dir_ok && !win_ok) begin
                        r_d.mpv     = 1'b1;
                        r_d.mpv_irq = 1'b1;
                    end else if (dir_ok) begin
                        r_d.st    = ST_RD;
                        r_d.bufn  = pk_buf;
                        r_d.to_cc = pk_cc;
                        r_d.dat   = ent.sel[1];
                        r_d.autos = ent.autos;
                        r_d.ofs   = ent.ofs;
                        r_d.idx   = ent.sel[0] ? '0 : IW'(HDR_WORDS);
                    end
                end
            end
            ST_RD: begin
                if (src_ack) begin
                    r_d.word = src_rdata;
                    r_d.st   = ST_WR;
                end
            end
            ST_WR: begin
                if (dst_ack) begin
                    if (r_q.idx == last_idx) begin
                        r_d.st = ST_IDLE;
                        if (r_q.to_cc) r_d.last_cc  = r_q.bufn;
                        else           r_d.last_sys = r_q.bufn;
                        r_d.done_irq = !done_mask_i[r_q.bufn];
                        r_d.tx       = r_q.to_cc && r_q.autos;
                    end else begin
                        r_d.st  = ST_RD;
                        r_d.idx = (r_q.idx == IW'(HDR_WORDS - 1) && !r_q.dat) ?
                                  IW'(STAT_IDX) : r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (trig_sys_i) r_d.p_sys[trig_buf_i] = 1'b1;
        if (trig_cc_i)  r_d.p_cc[trig_buf_i]  = 1'b1;
        if (evt_i && r_q.arm[evt_buf_i]) begin
            r_d.p_sys[evt_buf_i] = 1'b1;
            if (!r_q.cont[evt_buf_i]) r_d.arm[evt_buf_i] = 1'b0;
        end
        if (arm_i) begin
            r_d.arm[arm_buf_i]  = 1'b1;
            r_d.cont[arm_buf_i] = arm_cont_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_BUF; i++) tbl_q[i] <= '0;
        end else if (cfg_we_i) begin
            tbl_q[cfg_buf_i] <= {cfg_par_i, cfg_ent_i};
        end
    end

    assign cc_req_o   = (r_q.st == ST_RD && !r_q.to_cc) || (r_q.st == ST_WR && r_q.to_cc);
    assign cc_we_o    = (r_q.st == ST_WR) && r_q.to_cc;
    assign cc_addr_o  = CAW'(r_q.bufn) * CAW'(BUF_WORDS) + CAW'(r_q.idx);
    assign cc_wdata_o = r_q.word;
    assign sm_req_o   = (r_q.st == ST_RD && r_q.to_cc) || (r_q.st == ST_WR && !r_q.to_cc);
    assign sm_we_o    = (r_q.st == ST_WR) && !r_q.to_cc;
    assign sm_addr_o  = r_q.ofs + AW'(r_q.idx);
    assign sm_wdata_o = r_q.word;
    assign busy_o     = (r_q.st != ST_IDLE);
    assign cur_buf_o  = r_q.bufn;
    assign last_sys_o = r_q.last_sys;
    assign last_cc_o  = r_q.last_cc;
    assign done_irq_o = r_q.done_irq;
    assign par_flag_o = r_q.perr;
    assign par_irq_o  = r_q.par_irq;
    assign mpv_flag_o = r_q.mpv;
    assign mpv_irq_o  = r_q.mpv_irq;
    assign tx_req_o   = r_q.tx;
    assign tx_buf_o   = r_q.bufn;
    assign win_lo_w   = r_q.wlo;
    assign win_hi_w   = r_q.whi;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
    parameter int AW  = 16,
    parameter int CAW = 11
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cc_req,
    input logic           cc_we,
    input logic           cc_ack,
    input logic [CAW-1:0] cc_addr,
    input logic           sm_req,
    input logic [AW-1:0]  sm_addr,
    input logic           busy,
    input logic           mpv_flag,
    input logic           mpv_irq,
    input logic           par_flag,
    input logic           par_irq,
    input logic           done_irq,
    input logic           tx_req,
    input logic [AW-1:0]  win_lo,
    input logic [AW-1:0]  win_hi
);
    AST_SM_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        sm_req |-> (sm_addr >= win_lo && sm_addr < win_hi)); // R8
    AST_HALT_ON_VIOLATION: assert property (@(posedge clk) disable iff (!rst_n)
        mpv_flag |-> !busy); // R8
    AST_VIOLATION_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mpv_flag) |-> mpv_irq); // R8
    AST_PARITY_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        par_irq |-> par_flag); // R1
    AST_TX_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> $past(cc_req && cc_we && cc_ack)); // R11
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R10
    AST_CC_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_req && !cc_ack) |=> (cc_req && $stable(cc_addr))); // R2
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cc_req && sm_req)); // R2
endmodule

bind xfer_seq xfer_seq_chk #(.AW(AW), .CAW(CAW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cc_req   (cc_req_o),
    .cc_we    (cc_we_o),
    .cc_ack   (cc_ack_i),
    .cc_addr  (cc_addr_o),
    .sm_req   (sm_req_o),
    .sm_addr  (sm_addr_o),
    .busy     (busy_o),
    .mpv_flag (mpv_flag_o),
    .mpv_irq  (mpv_irq_o),
    .par_flag (par_flag_o),
    .par_irq  (par_irq_o),
    .done_irq (done_irq_o),
    .tx_req   (tx_req_o),
    .win_lo   (win_lo_w),
    .win_hi   (win_hi_w)
);

// File: tb/xfer_seq_bench.sv
module xfer_seq_bench;
    localparam int NB  = 128;
    localparam int BW  = 7;
    localparam int AW  = 16;
    localparam int CAW = 11;
    localparam int DW  = 32;
    localparam int BUFW = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0, cfg_par = 0, win_we = 0, prio = 0, clr_err = 0;
    logic [BW-1:0] cfg_buf = '0, trig_buf = '0, arm_buf = '0, evt_buf = '0;
    logic [22:0] cfg_ent = '0;
    logic [AW-1:0] win_lo = '0, win_hi = '0;
    logic trig_sys = 0, trig_cc = 0, arm = 0, arm_cont = 0, evt = 0;
    logic [NB-1:0] stat_upd = '0, data_upd = '0, done_mask = '0;
    logic cc_req, cc_we, sm_req, sm_we, cc_ack = 0, sm_ack = 0;
    logic [CAW-1:0] cc_addr;
    logic [AW-1:0] sm_addr;
    logic [DW-1:0] cc_wdata, sm_wdata, cc_rdata, sm_rdata;
    logic busy, done_irq, par_flag, par_irq, mpv_flag, mpv_irq, tx_req;
    logic [BW-1:0] cur_buf, last_sys, last_cc, tx_buf;

    int n_chk = 0, n_bad = 0, n_done = 0, n_tx = 0, n_par = 0, n_mpv = 0;
    int tx_seen = -1;
    bit finished = 0;
    string cur_tag = "R12";
    logic [64:0] expq [$];

    always #5 clk = ~clk;

    assign cc_rdata = 32'hCC00_0000 | 32'(cc_addr);
    assign sm_rdata = 32'h5500_0000 | 32'(sm_addr);

    xfer_seq u_xfer_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_we_i(cfg_we), .cfg_buf_i(cfg_buf), .cfg_ent_i(cfg_ent), .cfg_par_i(cfg_par),
        .win_we_i(win_we), .win_lo_i(win_lo), .win_hi_i(win_hi),
        .prio_i(prio), .clr_err_i(clr_err),
        .trig_sys_i(trig_sys), .trig_cc_i(trig_cc), .trig_buf_i(trig_buf),
        .arm_i(arm), .arm_cont_i(arm_cont), .arm_buf_i(arm_buf),
        .evt_i(evt), .evt_buf_i(evt_buf),
        .stat_upd_i(stat_upd), .data_upd_i(data_upd), .done_mask_i(done_mask),
        .cc_req_o(cc_req), .cc_we_o(cc_we), .cc_addr_o(cc_addr), .cc_wdata_o(cc_wdata),
        .cc_rdata_i(cc_rdata), .cc_ack_i(cc_ack),
        .sm_req_o(sm_req), .sm_we_o(sm_we), .sm_addr_o(sm_addr), .sm_wdata_o(sm_wdata),
        .sm_rdata_i(sm_rdata), .sm_ack_i(sm_ack),
        .busy_o(busy), .cur_buf_o(cur_buf), .last_sys_o(last_sys), .last_cc_o(last_cc),
        .done_irq_o(done_irq), .par_flag_o(par_flag), .par_irq_o(par_irq),
        .mpv_flag_o(mpv_flag), .mpv_irq_o(mpv_irq), .tx_req_o(tx_req), .tx_buf_o(tx_buf)
    );

    task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic see_write(input bit port, input int addr, input logic [31:0] data);
        if (expq.size() == 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL %s actual=write port%0d addr=%0h data=%0h expected=no write",
                     cur_tag, port, addr, data);
        end else begin
            chk(cur_tag, {port, 32'(addr), data}, expq.pop_front());
        end
    endtask

    // Memory responders and monitor: a handshake is logged when ack is raised,
    // since it completes at the following rising edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            cc_ack = 0;
            sm_ack = 0;
        end else begin
            cc_ack = cc_req && !cc_ack;
            sm_ack = sm_req && !sm_ack;
            if (cc_req && cc_we && cc_ack) see_write(1'b1, int'(cc_addr), cc_wdata);
            if (sm_req && sm_we && sm_ack) see_write(1'b0, int'(sm_addr), sm_wdata);
            if (done_irq) n_done++;
            if (par_irq)  n_par++;
            if (mpv_irq)  n_mpv++;
            if (tx_req) begin
                n_tx++;
                tx_seen = int'(tx_buf);
            end
        end
    end

    // Reference model: the word sequence a correct engine writes for one buffer.
    task automatic push_xfer(input int b, input bit to_cc, input int ofs, input bit hdr, input bit dat);
        for (int i = 0; i < BUFW; i++) begin
            bit take;
            take = (i < 4) ? hdr : (i < 8) ? dat : !to_cc;
            if (take) begin
                if (to_cc) expq.push_back({1'b1, 32'(b * BUFW + i), 32'h5500_0000 | 32'(ofs + i)});
                else       expq.push_back({1'b0, 32'(ofs + i), 32'hCC00_0000 | 32'(b * BUFW + i)});
            end
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ent(input int b, input int ofs, input int dirm, input int sel,
                          input bit autos, input int cond, input bit bad);
        cfg_buf = BW'(b);
        cfg_ent = {cond[1:0], autos, sel[1:0], dirm[1:0], ofs[15:0]};
        cfg_par = (^cfg_ent) ^ bad;
        cfg_we  = 1;
        cyc(1);
        cfg_we  = 0;
    endtask

    task automatic trig(input int b, input bit s, input bit c);
        trig_buf = BW'(b);
        trig_sys = s;
        trig_cc  = c;
        cyc(1);
        trig_sys = 0;
        trig_cc  = 0;
    endtask

    task automatic pulse_evt(input int b);
        evt_buf = BW'(b);
        evt = 1;
        cyc(1);
        evt = 0;
    endtask

    task automatic do_arm(input int b, input bit c);
        arm_buf  = BW'(b);
        arm_cont = c;
        arm = 1;
        cyc(1);
        arm = 0;
    endtask

    task automatic do_clr;
        clr_err = 1;
        cyc(1);
        clr_err = 0;
    endtask

    task automatic empty_q(input string tag);
        chk({tag, " pending expected writes"}, 65'(expq.size()), 65'd0);
        expq.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int d0;
        cyc(3);
        // R12: reset state
        chk("R12 busy", 65'(busy), 65'd0);
        chk("R12 flags", 65'({par_flag, mpv_flag, done_irq, tx_req, par_irq, mpv_irq}), 65'd0);
        chk("R12 last", 65'({last_sys, last_cc}), 65'd0);
        rst_n = 1;
        cyc(2);

        // R8: empty window after reset blocks everything
        cur_tag = "R8";
        wr_ent(5, 0, 3, 3, 0, 0, 0);
        trig(5, 1, 0);
        cyc(10);
        chk("R8 flag on empty window", 65'(mpv_flag), 65'd1);
        chk("R8 irq on empty window", 65'(n_mpv), 65'd1);
        chk("R8 engine idle", 65'(busy), 65'd0);
        do_clr();
        chk("R8 flag cleared", 65'(mpv_flag), 65'd0);
        win_lo = 16'h0100; win_hi = 16'h0400; win_we = 1;
        cyc(1);
        win_we = 0;

        // R2 R9 R10: full copy toward system memory
        cur_tag = "R2";
        d0 = n_done;
        wr_ent(3, 16'h0100, 3, 3, 0, 0, 0);
        push_xfer(3, 0, 16'h0100, 1, 1);
        trig(3, 1, 0);
        cyc(1);
        chk("R9 busy during copy", 65'(busy), 65'd1);
        chk("R9 current buffer", 65'(cur_buf), 65'd3);
        cyc(40);
        empty_q("R2");
        chk("R9 last to system", 65'(last_sys), 65'd3);
        chk("R10 one completion pulse", 65'(n_done - d0), 65'd1);

        // R11 R2: header-only copy to controller with auto-send
        cur_tag = "R11";
        wr_ent(3, 16'h0100, 3, 1, 1, 0, 0);
        push_xfer(3, 1, 16'h0100, 1, 0);
        trig(3, 0, 1);
        cyc(40);
        empty_q("R11");
        chk("R11 tx pulses", 65'(n_tx), 65'd1);
        chk("R11 tx buffer", 65'(tx_seen), 65'd3);
        chk("R9 last to controller", 65'(last_cc), 65'd3);

        // R2: data-only toward system, status word still last
        cur_tag = "R2";
        wr_ent(4, 16'h0200, 1, 2, 0, 0, 0);
        push_xfer(4, 0, 16'h0200, 0, 1);
        trig(4, 1, 0);
        cyc(40);
        empty_q("R2 data only");

        // R3: lowest number first
        cur_tag = "R3";
        wr_ent(20, 16'h0140, 1, 3, 0, 0, 0);
        wr_ent(7, 16'h0180, 1, 3, 0, 0, 0);
        wr_ent(9, 16'h01C0, 1, 3, 0, 0, 0);
        push_xfer(20, 0, 16'h0140, 1, 1);
        push_xfer(7, 0, 16'h0180, 1, 1);
        push_xfer(9, 0, 16'h01C0, 1, 1);
        trig(20, 1, 0);
        trig(9, 1, 0);
        trig(7, 1, 0);
        cyc(100);
        empty_q("R3");
        chk("R3 last served", 65'(last_sys), 65'd9);

        // R4: same buffer both directions
        cur_tag = "R4";
        wr_ent(10, 16'h0240, 3, 3, 0, 0, 0);
        prio = 1;
        push_xfer(20, 0, 16'h0140, 1, 1);
        push_xfer(10, 1, 16'h0240, 1, 1);
        push_xfer(10, 0, 16'h0240, 1, 1);
        trig(20, 1, 0);
        trig(10, 1, 1);
        cyc(100);
        empty_q("R4 prio=1");
        prio = 0;
        push_xfer(20, 0, 16'h0140, 1, 1);
        push_xfer(10, 0, 16'h0240, 1, 1);
        push_xfer(10, 1, 16'h0240, 1, 1);
        trig(20, 1, 0);
        trig(10, 1, 1);
        cyc(100);
        empty_q("R4 prio=0");

        // R1: parity failure
        cur_tag = "R1";
        wr_ent(11, 16'h0100, 3, 3, 0, 0, 1);
        trig(11, 1, 0);
        cyc(20);
        chk("R1 parity flag", 65'(par_flag), 65'd1);
        chk("R1 parity irq", 65'(n_par), 65'd1);
        empty_q("R1");
        do_clr();
        chk("R1 flag cleared", 65'(par_flag), 65'd0);

        // R5: disallowed direction and empty selection are dropped
        cur_tag = "R5";
        d0 = n_done;
        wr_ent(12, 16'h0100, 1, 3, 0, 0, 0);
        trig(12, 0, 1);
        wr_ent(13, 16'h0100, 3, 0, 0, 0, 0);
        trig(13, 1, 0);
        cyc(30);
        chk("R5 last_cc unchanged", 65'(last_cc), 65'd10);
        chk("R5 last_sys unchanged", 65'(last_sys), 65'd10);
        chk("R5 no completion", 65'(n_done - d0), 65'd0);
        empty_q("R5");

        // R6: one-shot and continuous event arming
        cur_tag = "R6";
        d0 = n_done;
        wr_ent(14, 16'h0100, 1, 3, 0, 0, 0);
        do_arm(14, 0);
        push_xfer(14, 0, 16'h0100, 1, 1);
        pulse_evt(14);
        cyc(40);
        pulse_evt(14);
        cyc(40);
        chk("R6 one-shot count", 65'(n_done - d0), 65'd1);
        empty_q("R6 one-shot");
        d0 = n_done;
        wr_ent(15, 16'h0180, 1, 3, 0, 0, 0);
        do_arm(15, 1);
        push_xfer(15, 0, 16'h0180, 1, 1);
        pulse_evt(15);
        cyc(40);
        push_xfer(15, 0, 16'h0180, 1, 1);
        pulse_evt(15);
        cyc(40);
        chk("R6 continuous count", 65'(n_done - d0), 65'd2);
        empty_q("R6 continuous");

        // R7: status-updated condition
        cur_tag = "R7";
        d0 = n_done;
        wr_ent(16, 16'h0100, 1, 3, 0, 1, 0);
        trig(16, 1, 0);
        cyc(30);
        chk("R7 dropped without update", 65'(n_done - d0), 65'd0);
        stat_upd[16] = 1;
        push_xfer(16, 0, 16'h0100, 1, 1);
        trig(16, 1, 0);
        cyc(40);
        chk("R7 copied after update", 65'(n_done - d0), 65'd1);
        empty_q("R7");

        // R10: masked completion
        cur_tag = "R10";
        d0 = n_done;
        done_mask[16] = 1;
        push_xfer(16, 0, 16'h0100, 1, 1);
        trig(16, 1, 0);
        cyc(40);
        chk("R10 masked pulse", 65'(n_done - d0), 65'd0);
        chk("R10 still completed", 65'(last_sys), 65'd16);
        empty_q("R10");

        // R8: span crossing the window end
        cur_tag = "R8";
        wr_ent(17, 16'h03FA, 1, 3, 0, 0, 0);
        trig(17, 1, 0);
        cyc(20);
        chk("R8 partial span flag", 65'(mpv_flag), 65'd1);
        chk("R8 partial span irq", 65'(n_mpv), 65'd2);
        empty_q("R8 partial");

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule